// File: doc/BRIEF.md
# Isochronous Receive Channel Dispatcher

This block takes isochronous packets out of a receive FIFO that a link layer fills and sends each one to the receive context that owns its channel. The first word of every packet is its header. The block reads the channel and the tag from the header and compares them with the settings of eight receive contexts. Each context has its own enable, channel, accepted-tag mask and descriptor pointer. One context can also be chosen to accept a whole set of channels, given by a 64-bit mask.

When a context claims the packet, the block requests the memory bus. Once the bus is granted, it reads one descriptor word at that context's descriptor pointer. That word is the base address of the destination buffer. The block then copies the packet body, word by word, to consecutive addresses starting at that base. When no context claims the packet, the body is still read out of the FIFO and thrown away, so the next header is never blocked.

Both the FIFO read port and the memory access port use valid/ready handshakes:
- A word moves only in a cycle where valid and ready are both high.
- A source that has raised valid holds it, and holds its data, until the transfer happens.
- While a body is being copied, the FIFO side is ready exactly when memory accepts the write. A slow memory therefore stalls the FIFO rather than losing data.
- The configuration ports and the request/grant pair are plain level signals.

Top module: `iso_rx_dispatch`

## Requirements
- R1: After reset, every context and the multi-channel selection are disabled, `fifo_ready` is 1, and `mem_req` and `mem_valid` are 0. A packet that arrives before any configuration is drained without any memory activity.
- R2: While idle, the block is ready on the FIFO and takes the next word as a header. The header fields are: channel in bits [13:8], tag in bits [15:14], and data length in bytes in bits [31:16]. The body is ceil(length/4) words long.
- R3: A context claims a packet when all three hold: it is enabled, its channel equals the header channel, and bit `tag` of its 4-bit tag mask is set.
- R4: A disabled context never claims a packet. A context whose tag-mask bit for the header tag is clear does not claim it.
- R5: When the multi-channel selection is enabled, the selected context claims a packet when all three hold: the context is enabled, bit `channel` of the 64-bit mask is set, and its tag bit is set. Its own channel field is ignored. With the selection disabled, that context falls back to single-channel matching.
- R6: When several contexts claim a packet, the lowest-indexed single-channel context wins. The multi-channel context wins only when no single-channel context claims the packet.
- R7: A claimed packet raises `mem_req` in the cycle after the header is taken. `mem_valid` stays low until `mem_gnt` is high. `mem_req` stays high until the final memory handshake of the packet, then drops.
- R8: The first memory access for a claimed packet is a read (`mem_we`=0) at the winning context's descriptor pointer. The returned word is the base address of the destination buffer.
- R9: Body word k (counting from 0) is written to base + 4k, in FIFO order. During the copy, `fifo_ready` follows `mem_ready` and `mem_valid` follows `fifo_valid`. The address holds steady while a write waits.
- R10: For an unclaimed packet, all of its body words are popped with `fifo_ready` high, and `mem_req` and `mem_valid` stay low.
- R11: A zero-length packet has no body. If it is claimed, the descriptor read is still made but no write follows. If it is unclaimed, the next FIFO word is taken as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one context's settings |
| cfg_idx | input | 3 | Context being written |
| cfg_enable | input | 1 | Context enable |
| cfg_chan | input | 6 | Context channel |
| cfg_tags | input | 4 | Accepted-tag mask, bit t accepts tag t |
| cfg_desc | input | 32 | Descriptor pointer |
| mc_we | input | 1 | Write the multi-channel selection |
| mc_enable | input | 1 | Multi-channel selection enable |
| mc_idx | input | 3 | Context that becomes multi-channel |
| mc_mask | input | 64 | Accepted channels, bit c accepts channel c |
| fifo_valid | input | 1 | FIFO word available |
| fifo_ready | output | 1 | Word taken this cycle when valid |
| fifo_data | input | 32 | FIFO word |
| mem_req | output | 1 | Memory bus request |
| mem_gnt | input | 1 | Memory bus grant, held while requested |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory access accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid at the read handshake |

## Verification
The bench aims at the matching corner cases:
- A channel owned by two single-channel contexts. A wrong priority sends the packet to the higher-indexed one.
- A channel in the multi-channel mask that is also owned by a single context. A design that favours the mask steals it.
- Disabled contexts and cleared tag bits. A careless design claims these packets.
- Lengths that are not a multiple of four. Truncating the word count leaves a stray word that is later read as a header.
- Zero-length packets, both claimed and unclaimed.
- Unclaimed packets, which must be drained silently.

Random stalls on the FIFO and on memory, plus a slow grant, check that no write is lost or duplicated and that no access starts before the grant.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  localparam int CH_W       = 6;
  localparam int TAG_W      = 2;
  localparam int NTAG       = 1 << TAG_W;
  localparam int NCHAN      = 1 << CH_W;
  localparam int CH_LSB     = 8;
  localparam int TAG_LSB    = 14;
  localparam int LEN_LSB    = 16;
  localparam int LEN_W      = 16;
  localparam int WORD_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_DESC,
    ST_COPY,
    ST_DRAIN
  } rx_state_e;
endpackage

// File: rtl/iso_rx_ctx_regs.sv
module iso_rx_ctx_regs
  import iso_rx_pkg::*;
#(
  parameter int NCTX = 8,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NCTX)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [IW-1:0]             cfg_idx,
  input  logic                      cfg_enable,
  input  logic [CH_W-1:0]           cfg_chan,
  input  logic [NTAG-1:0]           cfg_tags,
  input  logic [AW-1:0]             cfg_desc,
  input  logic                      mc_we,
  input  logic                      mc_enable,
  input  logic [IW-1:0]             mc_idx,
  input  logic [NCHAN-1:0]          mc_mask,
  output logic [NCTX-1:0]           en_q,
  output logic [NCTX-1:0][CH_W-1:0] chan_q,
  output logic [NCTX-1:0][NTAG-1:0] tags_q,
  output logic [NCTX-1:0][AW-1:0]   desc_q,
  output logic                      mc_en_q,
  output logic [IW-1:0]             mc_idx_q,
  output logic [NCHAN-1:0]          mc_mask_q
);
  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        chan_q[i] <= '0;
        tags_q[i] <= '0;
        desc_q[i] <= '0;
      end else if (cfg_we && cfg_idx == IW'(i)) begin
        en_q[i]   <= cfg_enable;
        chan_q[i] <= cfg_chan;
        tags_q[i] <= cfg_tags;
        desc_q[i] <= cfg_desc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_en_q   <= 1'b0;
      mc_idx_q  <= '0;
      mc_mask_q <= '0;
    end else if (mc_we) begin
      mc_en_q   <= mc_enable;
      mc_idx_q  <= mc_idx;
      mc_mask_q <= mc_mask;
    end
  end
endmodule

// File: rtl/iso_rx_match.sv
module iso_rx_match
  import iso_rx_pkg::*;
#(
  parameter int NCTX = 8,
  localparam int IW  = $clog2(NCTX)
) (
  input  logic [NCTX-1:0]           en_q,
  input  logic [NCTX-1:0][CH_W-1:0] chan_q,
  input  logic [NCTX-1:0][NTAG-1:0] tags_q,
  input  logic                      mc_en_q,
  input  logic [IW-1:0]             mc_idx_q,
  input  logic [NCHAN-1:0]          mc_mask_q,
  input  logic [CH_W-1:0]           hdr_chan,
  input  logic [TAG_W-1:0]          hdr_tag,
  output logic                      hit,
  output logic [IW-1:0]             win_idx
);
  logic [NCTX-1:0] single_hit;
  logic            multi_hit;

  for (genvar i = 0; i < NCTX; i++) begin : g_cmp
    logic is_multi;
    assign is_multi      = mc_en_q && (mc_idx_q == IW'(i));
    assign single_hit[i] = en_q[i] && !is_multi && tags_q[i][hdr_tag]
                           && (chan_q[i] == hdr_chan);
  end

  assign multi_hit = mc_en_q && en_q[mc_idx_q] && tags_q[mc_idx_q][hdr_tag]
                     && mc_mask_q[hdr_chan];

  always_comb begin
    hit     = multi_hit;
    win_idx = mc_idx_q;
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (single_hit[i]) begin
        hit     = 1'b1;
        win_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/iso_rx_seq.sv
module iso_rx_seq
  import iso_rx_pkg::*;
#(
  parameter int NCTX = 8,
  parameter int DW   = 32,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NCTX),
  localparam int CW  = LEN_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_valid,
  output logic          fifo_ready,
  input  logic [DW-1:0] fifo_data,
  input  logic          hit,
  input  logic [IW-1:0] win_idx,
  input  logic [AW-1:0] desc_ptr,
  output logic [IW-1:0] win_q,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  rx_state_e       st_q;
  logic [CW-1:0]   cnt_q;
  logic [AW-1:0]   buf_q;
  logic [CW-1:0]   body_words;
  logic            pop;

  assign body_words = CW'((32'(fifo_data[LEN_LSB +: LEN_W]) + WORD_BYTES - 1) / WORD_BYTES);
  assign pop        = fifo_valid && fifo_ready;

  always_comb begin
    fifo_ready = 1'b0;
    mem_valid  = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = buf_q;
    mem_wdata  = fifo_data;
    mem_req    = (st_q == ST_REQ) || (st_q == ST_DESC) || (st_q == ST_COPY);
    unique case (st_q)
      ST_IDLE, ST_DRAIN: fifo_ready = 1'b1;
      ST_DESC: begin
        mem_valid = 1'b1;
        mem_addr  = desc_ptr;
      end
      ST_COPY: begin
        mem_valid  = fifo_valid;
        mem_we     = 1'b1;
        fifo_ready = mem_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      buf_q <= '0;
      win_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pop) begin
          win_q <= win_idx;
          cnt_q <= body_words;
          if (hit)                  st_q <= ST_REQ;
          else if (body_words != 0) st_q <= ST_DRAIN;
        end
        ST_REQ: if (mem_gnt) st_q <= ST_DESC;
        ST_DESC: if (mem_ready) begin
          buf_q <= mem_rdata;
          st_q  <= (cnt_q == 0) ? ST_IDLE : ST_COPY;
        end
        ST_COPY: if (pop) begin
          buf_q <= buf_q + AW'(WORD_BYTES);
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == 1) st_q <= ST_IDLE;
        end
        ST_DRAIN: if (pop) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == 1) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iso_rx_dispatch.sv
module iso_rx_dispatch
  import iso_rx_pkg::*;
#(
  parameter int NCTX = 8,
  parameter int DW   = 32,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NCTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic              cfg_enable,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [NTAG-1:0]   cfg_tags,
  input  logic [AW-1:0]     cfg_desc,
  input  logic              mc_we,
  input  logic              mc_enable,
  input  logic [IW-1:0]     mc_idx,
  input  logic [NCHAN-1:0]  mc_mask,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  input  logic [DW-1:0]     fifo_data,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  logic [NCTX-1:0]           en_q;
  logic [NCTX-1:0][CH_W-1:0] chan_q;
  logic [NCTX-1:0][NTAG-1:0] tags_q;
  logic [NCTX-1:0][AW-1:0]   desc_q;
  logic                      mc_en_q;
  logic [IW-1:0]             mc_idx_q;
  logic [NCHAN-1:0]          mc_mask_q;
  logic                      hit;
  logic [IW-1:0]             win_idx;
  logic [IW-1:0]             win_q;

  iso_rx_ctx_regs #(.NCTX(NCTX), .AW(AW)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_enable, .cfg_chan, .cfg_tags,
    .cfg_desc, .mc_we, .mc_enable, .mc_idx, .mc_mask,
    .en_q, .chan_q, .tags_q, .desc_q, .mc_en_q, .mc_idx_q, .mc_mask_q
  );

  iso_rx_match #(.NCTX(NCTX)) u_match (
    .en_q, .chan_q, .tags_q, .mc_en_q, .mc_idx_q, .mc_mask_q,
    .hdr_chan (fifo_data[CH_LSB +: CH_W]),
    .hdr_tag  (fifo_data[TAG_LSB +: TAG_W]),
    .hit, .win_idx
  );

  iso_rx_seq #(.NCTX(NCTX), .DW(DW), .AW(AW)) u_seq (
    .clk, .rst_n, .fifo_valid, .fifo_ready, .fifo_data, .hit, .win_idx,
    .desc_ptr (desc_q[win_q]), .win_q,
    .mem_req, .mem_gnt, .mem_valid, .mem_ready, .mem_we, .mem_addr,
    .mem_wdata, .mem_rdata
  );
endmodule

// File: rtl/iso_rx_dispatch_chk.sv
module iso_rx_dispatch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_valid,
  input logic          fifo_ready,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  p_access_needs_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_req && mem_gnt));

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !(mem_valid && mem_ready)) |=> mem_req);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(mem_addr));

  p_write_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |=> (mem_addr == $past(mem_addr) + AW'(4)));

  p_write_consumes_fifo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |-> (fifo_valid && fifo_ready));

  p_quiet_without_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> !mem_valid);
endmodule

bind iso_rx_dispatch iso_rx_dispatch_chk #(.AW(AW)) u_chk (.*);

// File: tb/iso_rx_dispatch_bench.sv
module iso_rx_dispatch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 0, cfg_enable = 0, mc_we = 0, mc_enable = 0;
  logic [2:0]  cfg_idx = 0, mc_idx = 0;
  logic [5:0]  cfg_chan = 0;
  logic [3:0]  cfg_tags = 0;
  logic [31:0] cfg_desc = 0;
  logic [63:0] mc_mask = 0;
  logic        fifo_valid, fifo_ready, mem_req, mem_valid, mem_we, mem_ready;
  logic        mem_gnt = 0;
  logic [31:0] fifo_data, mem_addr, mem_wdata, mem_rdata;

  iso_rx_dispatch u_iso_rx_dispatch (.*);

  // FIFO model
  logic [31:0] fmem [256];
  int wr_ptr = 0, rd_ptr = 0;
  logic fhold = 0, fstall_en = 0, mstall_en = 0;
  logic [7:0] lf = 8'h5a;
  int gdly = 0, gcnt = 0;
  assign fifo_valid = (rd_ptr != wr_ptr) && (fhold || !(fstall_en && lf[1]));
  assign fifo_data  = fmem[rd_ptr % 256];
  assign mem_ready  = !(mstall_en && (lf[0] ^ lf[3]));
  assign mem_rdata  = 32'h0004_0000 + (mem_addr << 8);

  // Monitor logs
  logic [31:0] wa [64];
  logic [31:0] wd [64];
  int wr_n = 0, rd_n = 0, bad_gnt = 0;
  logic [31:0] rd_a = 0;
  logic saw_req = 0;

  always @(posedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    if (fifo_valid && fifo_ready) rd_ptr <= rd_ptr + 1;
    fhold <= fifo_valid && !fifo_ready;
    if (!mem_req) begin gcnt <= 0; mem_gnt <= 0; end
    else begin
      gcnt <= gcnt + 1;
      if (gcnt >= gdly) mem_gnt <= 1;
    end
    if (rst_n) begin
      if (mem_req) saw_req <= 1;
      if (mem_valid && !mem_gnt) bad_gnt <= bad_gnt + 1;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          if (wr_n < 64) begin wa[wr_n] <= mem_addr; wd[wr_n] <= mem_wdata; end
          wr_n <= wr_n + 1;
        end else begin
          rd_a <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0, pid = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_ctx(input int i, input bit en, input int ch, input logic [3:0] tg);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(i); cfg_enable = en; cfg_chan = 6'(ch);
    cfg_tags = tg; cfg_desc = 32'h100 + 32'(i) * 16;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_mc(input bit en, input int i, input logic [63:0] m);
    @(negedge clk);
    mc_we = 1; mc_enable = en; mc_idx = 3'(i); mc_mask = m;
    @(negedge clk);
    mc_we = 0;
  endtask

  // exp: 0..7 claiming context, 8 = dropped
  task automatic run_pkt(input logic [31:0] hdr, input int exp, input string req);
    int nw;
    logic [31:0] base;
    nw = (int'(hdr[31:16]) + 3) / 4;
    @(negedge clk);
    wr_n = 0; rd_n = 0; saw_req = 0; pid++;
    fmem[wr_ptr % 256] = hdr;
    for (int k = 0; k < nw; k++) fmem[(wr_ptr + 1 + k) % 256] = {8'(pid), 8'hA5, 16'(k)};
    wr_ptr = wr_ptr + 1 + nw;
    while (rd_ptr != wr_ptr) @(negedge clk);
    repeat (3) @(negedge clk);
    while (mem_req) @(negedge clk);
    repeat (2) @(negedge clk);
    if (exp == 8) begin
      chk(wr_n == 0 && rd_n == 0 && !saw_req, req, 32'(wr_n + rd_n), 0);
    end else begin
      base = 32'h0004_0000 + ((32'h100 + 32'(exp) * 16) << 8);
      chk(rd_n == 1 && rd_a == 32'h100 + 32'(exp) * 16, {req, " R8 desc"}, rd_a, 32'h100 + 32'(exp) * 16);
      chk(wr_n == nw, {req, " R9 count"}, 32'(wr_n), 32'(nw));
      for (int k = 0; k < nw && k < wr_n; k++) begin
        chk(wa[k] == base + 32'(4 * k) && wd[k] == {8'(pid), 8'hA5, 16'(k)},
            {req, " R9 word"}, wa[k], base + 32'(4 * k));
      end
    end
  endtask

  // {header, expected context}
  localparam logic [35:0] VEC [11] = '{
    {32'h000C4500, 4'd0},  // R3 R6: ch5 also on ctx2
    {32'h00050900, 4'd1},  // R2: 5 bytes -> 2 words
    {32'h00088900, 4'd8},  // R4: tag 2 not accepted by ctx1
    {32'h00040C00, 4'd8},  // R4: ctx3 disabled
    {32'h00101400, 4'd4},  // R6: single beats multi
    {32'h0007E800, 4'd5},  // R5: ch40 via mask
    {32'h00042100, 4'd6},  // R6: ch33 single over multi
    {32'h00013F00, 4'd5},  // R5: ch63 via mask
    {32'h00000000, 4'd7},  // R11: claimed zero length
    {32'h00093200, 4'd8},  // R10: drained
    {32'h00003300, 4'd8}   // R11: unclaimed zero length
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(fifo_ready == 1 && mem_req == 0 && mem_valid == 0, "R1 reset",
        {29'd0, fifo_ready, mem_req, mem_valid}, 32'h4);
    rst_n = 1;
    run_pkt(32'h000C4500, 8, "R1 unconfigured drop");

    set_ctx(0, 1, 5, 4'hF);  set_ctx(1, 1, 9, 4'h1);
    set_ctx(2, 1, 5, 4'hF);  set_ctx(3, 0, 12, 4'hF);
    set_ctx(4, 1, 20, 4'hF); set_ctx(5, 1, 20, 4'hF);
    set_ctx(6, 1, 33, 4'hF); set_ctx(7, 1, 0, 4'hF);
    set_mc(1, 5, (64'd1 << 20) | (64'd1 << 33) | (64'd1 << 40) | (64'd1 << 63));

    for (int v = 0; v < 11; v++) run_pkt(VEC[v][35:4], int'(VEC[v][3:0]), "R2 vector");

    // R9 / R7: stalls on both sides and a slow grant
    fstall_en = 1; mstall_en = 1; gdly = 5;
    run_pkt(32'h001D4500, 0, "R9 stalled copy");
    run_pkt(32'h0007E800, 5, "R9 stalled multi");
    run_pkt(32'h00093200, 8, "R10 stalled drain");
    chk(bad_gnt == 0, "R7 access before grant", 32'(bad_gnt), 0);
    fstall_en = 0; mstall_en = 0; gdly = 0;

    // R5: multi disabled, ctx5 back to single channel 20 (ctx4 still wins)
    set_mc(0, 5, '1);
    run_pkt(32'h0007E800, 8, "R5 multi off");
    set_ctx(4, 0, 20, 4'hF);
    run_pkt(32'h00041400, 5, "R5 fallback single");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule